// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block gathers 256 level-sensitive interrupt sources, arranged as 32 groups of 8, and reduces them to one interrupt line per group. Every source has its own enable bit. Software changes the enables only through two write-one registers per bank. One register sets enable bits and the other clears them, so a write never disturbs the enables of sources it does not name.

Four groups share each 32-bit register bank. Group g lives in bank g/4, in byte lane g mod 4. Each bank exposes four words: enable-set, enable-clear, raw status and masked status. A separate pending word has one bit per group, so an interrupt handler can find the groups that need service with a single read.

Register reads are combinational from the address. Enable writes take effect at the clock edge on which the write is sampled.

Top module: `irq_combiner_top`

## Requirements
- R1: After reset every enable bit is 0, every group output is low and the pending word at byte offset 0x100 reads 0, whatever the source levels.
- R2: A write to byte offset 0x10*n (bank n enable-set) enables each source whose data bit is 1; bits written as 0 leave their enables unchanged.
- R3: A write to byte offset 0x10*n+0x4 (bank n enable-clear) disables each source whose data bit is 1; bits written as 0 leave their enables unchanged.
- R4: Raw status at offset 0x10*n+0x8 returns the source levels of bank n regardless of enables, with group g in bank g/4 at bits (g mod 4)*8 to (g mod 4)*8+7.
- R5: Masked status at offset 0x10*n+0xC returns raw status AND enable for bank n.
- R6: Group output g is high exactly when at least one of the 8 sources of group g is both asserted and enabled.
- R7: The pending word at offset 0x100 has bit g equal to group output g.
- R8: Reading either the enable-set or the enable-clear offset of bank n returns the current enable bits of bank n.
- R9: Writes to raw status, masked status or the pending word leave all enables unchanged.
- R10: Any other offset reads as 0 and ignores writes: offsets 0x80 to 0xFF, offsets above 0x100, and every offset whose two low bits are not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | 256 | Interrupt source levels; source b of group g at bit g*8+b |
| reg_addr | input | 9 | Register byte address |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| group_irq | output | 32 | One interrupt line per group |

## Verification
The combiner is first driven with directed patterns. A single enabled bit in a single group shows whether the bank and lane packing is correct. All sources asserted with no enables shows whether the raw path is kept apart from the masked path. A set write or clear write with zero data shows whether zero bits really leave enables alone.

Constrained-random rounds then change the source levels and issue writes to every kind of offset: set, clear, status, pending, unmapped and unaligned. After each write the bench compares the group lines and reads of random addresses against a reference model of the enables kept in the bench. This exposes lane swaps, bank aliasing and writes that leak through to the enables from decoded-but-read-only offsets.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;

  parameter int GRP_W        = 8;
  parameter int NUM_GRP      = 32;
  parameter int REG_W        = 32;
  parameter int ADDR_W       = 9;
  parameter int BANK_STRIDE  = 16;

  localparam int GRP_PER_BANK = REG_W / GRP_W;
  localparam int NUM_BANK     = NUM_GRP / GRP_PER_BANK;
  localparam int NUM_SRC      = NUM_GRP * GRP_W;
  localparam int BANK_W       = $clog2(NUM_BANK);
  localparam int BANK_LSB     = $clog2(BANK_STRIDE);
  localparam int MAP_TOP      = NUM_BANK * BANK_STRIDE;
  localparam logic [ADDR_W-1:0] PEND_OFF = ADDR_W'(256);

  typedef enum logic [2:0] {
    RK_NONE,
    RK_SET,
    RK_CLR,
    RK_RAW,
    RK_MSK,
    RK_PEND
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e         kind;
    logic [BANK_W-1:0] bank;
  } reg_sel_t;

  // Address decode: bank window, word within bank, or the pending word.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.bank = '0;
    if (a == PEND_OFF) begin
      s.kind = RK_PEND;
    end else if (a[1:0] == 2'b00 && a < ADDR_W'(MAP_TOP)) begin
      s.bank = a[BANK_LSB +: BANK_W];
      case (a[3:2])
        2'd0:    s.kind = RK_SET;
        2'd1:    s.kind = RK_CLR;
        2'd2:    s.kind = RK_RAW;
        default: s.kind = RK_MSK;
      endcase
    end
    return s;
  endfunction

  // Next enable value for one bank, clear winning over set.
  function automatic logic [REG_W-1:0] next_enable(
    input logic [REG_W-1:0] cur,
    input logic             set_we,
    input logic             clr_we,
    input logic [REG_W-1:0] wdata);
    logic [REG_W-1:0] setm, clrm;
    setm = set_we ? wdata : '0;
    clrm = clr_we ? wdata : '0;
    return (cur | setm) & ~clrm;
  endfunction

  function automatic logic any_masked(input logic [GRP_W-1:0] raw,
                                      input logic [GRP_W-1:0] en);
    return |(raw & en);
  endfunction

endpackage

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_comb_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);

  logic [W-1:0] en_d;

  always_comb en_d = W'(next_enable(REG_W'(en_q), set_we, clr_we, REG_W'(wdata)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  // R2: set bits are on after the write
  p_set_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((en_q & $past(wdata)) == $past(wdata)));

  // R2: bits not named in a set write keep their value
  p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !clr_we) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));

  // R3: cleared bits are off after the write
  p_clear_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & $past(wdata)) == '0));

  // R9: no enable write, no change
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(en_q));

endmodule

// File: rtl/irq_group_reduce.sv
module irq_group_reduce
  import irq_comb_pkg::*;
#(
  parameter int GW = GRP_W
) (
  input  logic [GW-1:0] raw,
  input  logic [GW-1:0] en,
  output logic          irq
);

  always_comb irq = any_masked(GRP_W'(raw), GRP_W'(en));

endmodule

// File: rtl/irq_csr_read.sv
module irq_csr_read
  import irq_comb_pkg::*;
(
  input  reg_sel_t             sel,
  input  logic [NUM_SRC-1:0]   en_flat,
  input  logic [NUM_SRC-1:0]   raw_flat,
  input  logic [NUM_GRP-1:0]   pend,
  output logic [REG_W-1:0]     rdata
);

  logic [REG_W-1:0] en_word;
  logic [REG_W-1:0] raw_word;

  always_comb begin
    en_word  = en_flat[int'(sel.bank)*REG_W +: REG_W];
    raw_word = raw_flat[int'(sel.bank)*REG_W +: REG_W];
    case (sel.kind)
      RK_SET, RK_CLR: rdata = en_word;
      RK_RAW:         rdata = raw_word;
      RK_MSK:         rdata = raw_word & en_word;
      RK_PEND:        rdata = REG_W'(pend);
      default:        rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_combiner_top.sv
module irq_combiner_top
  import irq_comb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_level,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic [NUM_GRP-1:0]  group_irq
);

  reg_sel_t           sel;
  logic [NUM_BANK-1:0] bank_set_we;
  logic [NUM_BANK-1:0] bank_clr_we;
  logic [NUM_SRC-1:0]  en_flat;

  always_comb sel = decode_addr(reg_addr);

  for (genvar n = 0; n < NUM_BANK; n++) begin : g_bank
    assign bank_set_we[n] = reg_we && sel.kind == RK_SET && sel.bank == BANK_W'(n);
    assign bank_clr_we[n] = reg_we && sel.kind == RK_CLR && sel.bank == BANK_W'(n);

    irq_enable_bank #(.W(REG_W)) u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (bank_set_we[n]),
      .clr_we (bank_clr_we[n]),
      .wdata  (reg_wdata),
      .en_q   (en_flat[n*REG_W +: REG_W])
    );
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    irq_group_reduce #(.GW(GRP_W)) u_red (
      .raw (src_level[g*GRP_W +: GRP_W]),
      .en  (en_flat[g*GRP_W +: GRP_W]),
      .irq (group_irq[g])
    );

    // R6: a group line implies an enabled, asserted source in that group
    p_group_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      group_irq[g] |-> ((src_level[g*GRP_W +: GRP_W] & en_flat[g*GRP_W +: GRP_W]) != '0));
  end

  irq_csr_read u_rd (
    .sel      (sel),
    .en_flat  (en_flat),
    .raw_flat (src_level),
    .pend     (group_irq),
    .rdata    (reg_rdata)
  );

  // R7: pending word mirrors the group lines
  p_pending_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == PEND_OFF) |-> (reg_rdata == REG_W'(group_irq)));

  // R10: unaligned offsets read zero
  p_unaligned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0));

  // R10: no bank sees a write strobe for unmapped offsets
  p_unmapped_no_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] != 2'b00) |-> ((bank_set_we | bank_clr_we) == '0));

  // R4: bank 0 raw status follows the source pins
  p_raw_bank0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(8)) |-> (reg_rdata == src_level[REG_W-1:0]));

  // set and clear never strobe the same bank together
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_set_we | bank_clr_we));

endmodule

// File: tb/irq_combiner_top_test.sv
`timescale 1ns/1ps
module irq_combiner_top_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] src = '0;
  logic [8:0]   addr = '0;
  logic         we = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [31:0]  girq;

  logic [255:0] m_en = '0;
  int total = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_combiner_top uut (
    .clk(clk), .rst_n(rst_n), .src_level(src), .reg_addr(addr),
    .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata), .group_irq(girq));

  function automatic logic [31:0] exp_groups();
    logic [31:0] r;
    for (int g = 0; g < 32; g++) begin
      r[g] = 1'b0;
      for (int b = 0; b < 8; b++) r[g] = r[g] | (src[g*8+b] & m_en[g*8+b]);
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [8:0] a);
    int bank, word;
    if (a == 9'h100) return exp_groups();
    if ((a % 4) != 0 || a >= 9'h080) return 32'h0;
    bank = a / 16;
    word = (a % 16) / 4;
    case (word)
      0, 1:    return m_en[bank*32 +: 32];
      2:       return src[bank*32 +: 32];
      default: return src[bank*32 +: 32] & m_en[bank*32 +: 32];
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    int bank;
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if ((a % 4) == 0 && a < 9'h080) begin
      bank = a / 16;
      if ((a % 16) == 0) m_en[bank*32 +: 32] = m_en[bank*32 +: 32] | d;
      if ((a % 16) == 4) m_en[bank*32 +: 32] = m_en[bank*32 +: 32] & ~d;
    end
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a);
    addr = a;
    #1;
    chk(req, rdata, exp_read(a));
  endtask

  task automatic rand_src();
    for (int i = 0; i < 8; i++) src[i*32 +: 32] = $urandom;
  endtask

  initial begin
    void'($urandom(32'd4242));
    src = '1;
    repeat (3) @(negedge clk);
    // R1: reset state with all sources high
    chk("R1 group_irq", girq, 32'h0);
    addr = 9'h100; #1; chk("R1 pending", rdata, 32'h0);
    for (int n = 0; n < 8; n++) begin
      addr = 9'(n*16); #1; chk("R1 enable", rdata, 32'h0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", girq, 32'h0);

    // R4 / R5: all raw high, none enabled
    for (int n = 0; n < 8; n++) begin
      rd_chk("R4 raw all-ones", 9'(n*16+8));
      rd_chk("R5 masked none-enabled", 9'(n*16+12));
    end

    // R2: single bit, group 5 source 3 -> bank 1 bit 11
    src = '0;
    src[5*8+3] = 1'b1;
    wr(9'h010, 32'h0000_0800);
    #1 chk("R2 R6 group 5 line", girq, 32'h0000_0020);
    rd_chk("R7 pending group 5", 9'h100);
    rd_chk("R8 enable via set addr", 9'h010);
    rd_chk("R8 enable via clr addr", 9'h014);
    // R2: zero-data set write changes nothing
    wr(9'h010, 32'h0);
    rd_chk("R2 zero set keeps", 9'h010);
    // R3: zero-data clear write changes nothing
    wr(9'h014, 32'h0);
    #1 chk("R3 zero clear keeps", girq, 32'h0000_0020);
    // R9: writes to status and pending ignored
    wr(9'h018, 32'hFFFF_FFFF);
    wr(9'h01C, 32'hFFFF_FFFF);
    wr(9'h100, 32'hFFFF_FFFF);
    rd_chk("R9 status writes ignored", 9'h010);
    // R10: unmapped and unaligned
    wr(9'h080, 32'hFFFF_FFFF);
    wr(9'h011, 32'hFFFF_FFFF);
    wr(9'h104, 32'hFFFF_FFFF);
    rd_chk("R10 writes ignored", 9'h000);
    rd_chk("R10 unaligned reads zero", 9'h011);
    rd_chk("R10 gap reads zero", 9'h0C0);
    rd_chk("R10 above pending reads zero", 9'h1F0);
    // R3: clear the bit
    wr(9'h014, 32'h0000_0800);
    #1 chk("R3 clear drops group 5", girq, 32'h0);
    rd_chk("R3 enable cleared", 9'h010);
    // R6: top group, last source
    src[255] = 1'b1;
    wr(9'h070, 32'h8000_0000);
    #1 chk("R6 group 31 line", girq, 32'h8000_0000);

    // constrained random rounds
    for (int it = 0; it < 400; it++) begin
      logic [8:0] a;
      int pick;
      rand_src();
      pick = $urandom_range(0, 9);
      case (pick)
        0, 1, 2: a = 9'($urandom_range(0, 7) * 16);
        3, 4:    a = 9'($urandom_range(0, 7) * 16 + 4);
        5:       a = 9'($urandom_range(0, 7) * 16 + 8 + 4*$urandom_range(0, 1));
        6:       a = 9'h100;
        default: a = 9'($urandom);
      endcase
      wr(a, $urandom & $urandom);
      #1 chk("R6 random group lines", girq, exp_groups());
      rd_chk("R7 random pending", 9'h100);
      rd_chk("R8 random enable", 9'($urandom_range(0, 7) * 16 + 4*$urandom_range(0, 1)));
      rd_chk("R4 R5 random status", 9'($urandom_range(0, 7) * 16 + 8 + 4*$urandom_range(0, 1)));
      rd_chk("R10 random address", 9'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule